// File: doc/BRIEF.md
# DMA Stream Address and Count Sequencer

This block is the per-stream sequencer of a DMA controller. Software loads a peripheral base address, two memory base pointers and an item count. It then writes the stream enable. Each time the bus side reports a finished beat, the sequencer moves the peripheral and memory addresses forward by their item widths and takes one off the remaining count. The direction setting decides which of the two current addresses is the read side and which is the write side.

There are three ways a stream can end or repeat. In normal mode the stream stops after the last item. In circular mode the count and both addresses return to their start values, and the stream keeps running. In double-buffer mode, circular operation is forced on and each wrap swaps the active memory pointer, so software can refill the idle buffer. Peripheral flow control ignores the count and reports it as all ones; the stream ends on the beat that carries the peripheral's last-item signal. A start request with an illegal mode combination is refused and raises an error flag.

The controller has two states. ST_IDLE moves to ST_RUN on a legal enable write with either a nonzero count or flow control on. ST_RUN loops on itself for ordinary beats and for circular wraps. ST_RUN returns to ST_IDLE in three cases: the last beat in normal mode, a flow-controlled beat marked last, or a write that clears the enable.

Top module: `dma_seq_engine`

## Requirements
- R1: After reset, active, xfer_done, cfg_err and cur_mem are 0, both current addresses are 0 and cnt_val is 0.
- R2: On each beat, a side with its increment bit set adds 1, 2 or 4 to its address for width codes 0, 1 and 2. A side with the increment bit clear keeps its address unchanged.
- R3: Without flow control, each beat lowers cnt_val by one. In normal mode the beat that brings it to zero pulses xfer_done for exactly one cycle and clears active.
- R4: In circular mode, the beat that brings the count to zero reloads the programmed count and returns both addresses to their bases. It pulses xfer_done once, and active stays 1.
- R5: Double-buffer mode behaves as circular mode even with circ_en low. The stream starts on pointer 0 (cur_mem=0), and each wrap toggles cur_mem and moves m_addr to the other pointer's base. A pointer written during a run takes effect at that pointer's next use.
- R6: With flow control on, cnt_val reads all ones and the count never ends the stream. The stream ends, with a one-cycle xfer_done pulse, on the beat where periph_last is high.
- R7: A start request is refused and cfg_err is set in any of these cases: dir code 3 is used; a width code of 3 is used; memory-to-memory (dir=2) is combined with circular, double-buffer or direct mode; flow control is combined with dir=2, circular or double-buffer mode; or direct mode is used with unequal widths. A later legal start clears cfg_err.
- R8: Enabling with a programmed count of 0 and flow control off pulses xfer_done once and leaves active at 0.
- R9: For dir=0 (memory to peripheral), src_addr is m_addr and dst_addr is p_addr. For dir=1 and dir=2, src_addr is p_addr and dst_addr is m_addr.
- R10: Writing the enable with en_val=0 while running clears active without an xfer_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | AW | Write data for the load strobes (count uses the low CW bits) |
| ld_padr | input | 1 | Load the peripheral base address |
| ld_m0 | input | 1 | Load memory pointer 0 |
| ld_m1 | input | 1 | Load memory pointer 1 |
| ld_cnt | input | 1 | Load the programmed item count |
| en_wr | input | 1 | Write strobe for the stream enable |
| en_val | input | 1 | Enable value written with en_wr |
| dir | input | 2 | Direction: 0 mem to periph, 1 periph to mem, 2 mem to mem |
| p_inc | input | 1 | Peripheral address increment |
| m_inc | input | 1 | Memory address increment |
| p_wid | input | 2 | Peripheral item width code (0=1 B, 1=2 B, 2=4 B) |
| m_wid | input | 2 | Memory item width code |
| circ_en | input | 1 | Circular mode |
| dbuf_en | input | 1 | Double-buffer mode |
| pflow_en | input | 1 | Peripheral flow control |
| direct_en | input | 1 | Direct (unbuffered) mode |
| beat_done | input | 1 | One item transferred |
| periph_last | input | 1 | Peripheral marks the current beat as last |
| p_addr | output | AW | Current peripheral address |
| m_addr | output | AW | Current memory address |
| src_addr | output | AW | Read-side address |
| dst_addr | output | AW | Write-side address |
| cur_mem | output | 1 | Active memory pointer |
| cnt_val | output | CW | Remaining count (all ones under flow control) |
| active | output | 1 | Stream running |
| xfer_done | output | 1 | One-cycle completion or wrap pulse |
| cfg_err | output | 1 | Last start request was illegal |

## Verification
The assertions assume that the configuration inputs stay constant while the stream is active. They also assume that beat_done and periph_last are only meaningful during a run. The bench honours both assumptions: it changes configuration only in idle cycles, after the previous stream has ended or been aborted. It drives every strobe for exactly one cycle, away from the active edge. Pointer rewrites during a run go only to the memory pointer that is not in use, so the wrap checks observe the documented hand-over.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        DIR_M2P = 2'd0,
        DIR_P2M = 2'd1,
        DIR_M2M = 2'd2
    } dir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam logic [1:0] WID_BAD = 2'd3;
endpackage

// File: rtl/dma_seq_cfgchk.sv
module dma_seq_cfgchk
    import dma_seq_pkg::*;
(
    input  logic [1:0] dir,
    input  logic [1:0] p_wid,
    input  logic [1:0] m_wid,
    input  logic       circ_en,
    input  logic       dbuf_en,
    input  logic       pflow_en,
    input  logic       direct_en,
    output logic       legal
);
    logic is_mm;
    logic bad_dir;
    logic bad_wid;
    logic bad_mm;
    logic bad_flow;
    logic bad_direct;

    always_comb begin
        is_mm      = (dir == DIR_M2M);
        bad_dir    = (dir == 2'd3);
        bad_wid    = (p_wid == WID_BAD) || (m_wid == WID_BAD);
        bad_mm     = is_mm && (circ_en || dbuf_en || direct_en);
        bad_flow   = pflow_en && (is_mm || circ_en || dbuf_en);
        bad_direct = direct_en && (p_wid != m_wid);
        legal      = !(bad_dir || bad_wid || bad_mm || bad_flow || bad_direct);
    end
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [AW-1:0] restart_val,
    input  logic          step,
    input  logic          inc_en,
    input  logic [1:0]    wid,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] stride;

    always_comb stride = AW'(1) << wid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (restart)
            addr <= restart_val;
        else if (step && inc_en)
            addr <= addr + stride;
    end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          at_one
);
    always_comb at_one = (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] wdata,
    input  logic          ld_padr,
    input  logic          ld_m0,
    input  logic          ld_m1,
    input  logic          ld_cnt,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic [1:0]    dir,
    input  logic          p_inc,
    input  logic          m_inc,
    input  logic [1:0]    p_wid,
    input  logic [1:0]    m_wid,
    input  logic          circ_en,
    input  logic          dbuf_en,
    input  logic          pflow_en,
    input  logic          direct_en,
    input  logic          beat_done,
    input  logic          periph_last,
    output logic [AW-1:0] p_addr,
    output logic [AW-1:0] m_addr,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          cur_mem,
    output logic [CW-1:0] cnt_val,
    output logic          active,
    output logic          xfer_done,
    output logic          cfg_err
);
    localparam logic [CW-1:0] CNT_FLOW = '1;

    seq_state_e    state, state_nx;
    logic [AW-1:0] p_base, m0_base, m1_base, m_restart_val;
    logic [CW-1:0] cnt_prog, cnt_live, cnt_load_val;
    logic          legal, at_one, cnt_load;
    logic          start_req, zero_start, go, beat, last_cnt;
    logic          loop_mode, wrap, finish, abort, restart;

    dma_seq_cfgchk cfg_i (
        .dir       (dir),
        .p_wid     (p_wid),
        .m_wid     (m_wid),
        .circ_en   (circ_en),
        .dbuf_en   (dbuf_en),
        .pflow_en  (pflow_en),
        .direct_en (direct_en),
        .legal     (legal)
    );

    always_comb begin
        loop_mode  = circ_en || dbuf_en;
        start_req  = (state == ST_IDLE) && en_wr && en_val && legal;
        zero_start = start_req && !pflow_en && (cnt_prog == '0);
        go         = start_req && !zero_start;
        beat       = (state == ST_RUN) && beat_done;
        last_cnt   = beat && !pflow_en && at_one;
        wrap       = last_cnt && loop_mode;
        finish     = (last_cnt && !loop_mode) || (beat && pflow_en && periph_last);
        abort      = (state == ST_RUN) && en_wr && !en_val;
        restart    = go || wrap;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go) state_nx = ST_RUN;
            ST_RUN:  if (finish || abort) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // programmed values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_base   <= '0;
            m0_base  <= '0;
            m1_base  <= '0;
            cnt_prog <= '0;
        end else begin
            if (ld_padr) p_base   <= wdata;
            if (ld_m0)   m0_base  <= wdata;
            if (ld_m1)   m1_base  <= wdata;
            if (ld_cnt)  cnt_prog <= wdata[CW-1:0];
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            cfg_err   <= 1'b0;
            cur_mem   <= 1'b0;
        end else begin
            xfer_done <= zero_start || wrap || finish;
            if ((state == ST_IDLE) && en_wr && en_val)
                cfg_err <= !legal;
            if (go)
                cur_mem <= 1'b0;
            else if (wrap && dbuf_en)
                cur_mem <= !cur_mem;
        end
    end

    always_comb begin
        if (go)           m_restart_val = m0_base;
        else if (dbuf_en) m_restart_val = cur_mem ? m0_base : m1_base;
        else              m_restart_val = cur_mem ? m1_base : m0_base;
        cnt_load     = restart || (ld_cnt && state == ST_IDLE);
        cnt_load_val = restart ? cnt_prog : wdata[CW-1:0];
    end

    dma_seq_addr #(.AW(AW)) padr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .restart_val (p_base),
        .step        (beat),
        .inc_en      (p_inc),
        .wid         (p_wid),
        .addr        (p_addr)
    );

    dma_seq_addr #(.AW(AW)) madr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .restart_val (m_restart_val),
        .step        (beat),
        .inc_en      (m_inc),
        .wid         (m_wid),
        .addr        (m_addr)
    );

    dma_seq_cnt #(.CW(CW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (beat && !pflow_en),
        .cnt      (cnt_live),
        .at_one   (at_one)
    );

    always_comb begin
        active   = (state == ST_RUN);
        cnt_val  = pflow_en ? CNT_FLOW : cnt_live;
        src_addr = (dir == DIR_M2P) ? m_addr : p_addr;
        dst_addr = (dir == DIR_M2P) ? p_addr : m_addr;
    end
endmodule

// File: rtl/dma_seq_engine_chk.sv
module dma_seq_engine_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_wr,
    input logic          en_val,
    input logic          beat_done,
    input logic          circ_en,
    input logic          dbuf_en,
    input logic          pflow_en,
    input logic [AW-1:0] p_addr,
    input logic [AW-1:0] m_addr,
    input logic          cur_mem,
    input logic [CW-1:0] cnt_val,
    input logic          active,
    input logic          xfer_done,
    input logic          cfg_err
);
    // R7
    cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !active);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && beat_done && !pflow_en && !circ_en && !dbuf_en && cnt_val > CW'(1)
        |=> cnt_val == $past(cnt_val) - CW'(1));

    // R2
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && beat_done) && !en_wr |=> $stable(p_addr) && $stable(m_addr));

    // R5
    mem_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && beat_done) && !en_wr |=> $stable(cur_mem));

    // R4
    wrap_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && beat_done && (circ_en || dbuf_en) && !pflow_en && cnt_val == CW'(1)
        && !(en_wr && !en_val) |=> active && xfer_done);

    // R10
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && en_wr && !en_val |=> !active);
endmodule

bind dma_seq_engine dma_seq_engine_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .beat_done (beat_done),
    .circ_en   (circ_en),
    .dbuf_en   (dbuf_en),
    .pflow_en  (pflow_en),
    .p_addr    (p_addr),
    .m_addr    (m_addr),
    .cur_mem   (cur_mem),
    .cnt_val   (cnt_val),
    .active    (active),
    .xfer_done (xfer_done),
    .cfg_err   (cfg_err)
);

// File: tb/dma_seq_engine_tb_top.sv
module dma_seq_engine_tb_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] wdata = '0;
    logic          ld_padr = 0, ld_m0 = 0, ld_m1 = 0, ld_cnt = 0;
    logic          en_wr = 0, en_val = 0;
    logic [1:0]    dir = 2'd0, p_wid = 2'd0, m_wid = 2'd0;
    logic          p_inc = 0, m_inc = 0;
    logic          circ_en = 0, dbuf_en = 0, pflow_en = 0, direct_en = 0;
    logic          beat_done = 0, periph_last = 0;
    logic [AW-1:0] p_addr, m_addr, src_addr, dst_addr;
    logic          cur_mem, active, xfer_done, cfg_err;
    logic [CW-1:0] cnt_val;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_seq_engine #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wdata(wdata),
        .ld_padr(ld_padr), .ld_m0(ld_m0), .ld_m1(ld_m1), .ld_cnt(ld_cnt),
        .en_wr(en_wr), .en_val(en_val), .dir(dir),
        .p_inc(p_inc), .m_inc(m_inc), .p_wid(p_wid), .m_wid(m_wid),
        .circ_en(circ_en), .dbuf_en(dbuf_en), .pflow_en(pflow_en),
        .direct_en(direct_en), .beat_done(beat_done), .periph_last(periph_last),
        .p_addr(p_addr), .m_addr(m_addr), .src_addr(src_addr), .dst_addr(dst_addr),
        .cur_mem(cur_mem), .cnt_val(cnt_val), .active(active),
        .xfer_done(xfer_done), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input int which, input logic [31:0] v);
        @(negedge clk);
        wdata = v;
        ld_padr = (which == 0);
        ld_m0   = (which == 1);
        ld_m1   = (which == 2);
        ld_cnt  = (which == 3);
        @(negedge clk);
        ld_padr = 0; ld_m0 = 0; ld_m1 = 0; ld_cnt = 0;
    endtask

    task automatic enable(input logic v);
        @(negedge clk);
        en_wr = 1; en_val = v;
        @(negedge clk);
        en_wr = 0; en_val = 0;
    endtask

    task automatic beat(input logic last);
        @(negedge clk);
        beat_done = 1; periph_last = last;
        @(negedge clk);
        beat_done = 0; periph_last = 0;
    endtask

    task automatic set_cfg(input logic [1:0] d, input logic pi, input logic [1:0] pw,
                           input logic mi, input logic [1:0] mw,
                           input logic ci, input logic db, input logic pf, input logic dr);
        @(negedge clk);
        dir = d; p_inc = pi; p_wid = pw; m_inc = mi; m_wid = mw;
        circ_en = ci; dbuf_en = db; pflow_en = pf; direct_en = dr;
    endtask

    task automatic t_reset;
        chk("R1 active", active, 0);
        chk("R1 xfer_done", xfer_done, 0);
        chk("R1 cfg_err", cfg_err, 0);
        chk("R1 cur_mem", cur_mem, 0);
        chk("R1 p_addr", p_addr, 0);
        chk("R1 m_addr", m_addr, 0);
        chk("R1 cnt_val", cnt_val, 0);
    endtask

    task automatic t_normal;
        set_cfg(2'd0, 1, 2'd1, 1, 2'd2, 0, 0, 0, 0);
        load(0, 32'h1000); load(1, 32'h2000); load(3, 3);
        enable(1);
        chk("R3 active after start", active, 1);
        chk("R3 count start", cnt_val, 3);
        chk("R9 m2p src", src_addr, 32'h2000);
        chk("R9 m2p dst", dst_addr, 32'h1000);
        beat(0);
        chk("R3 count dec", cnt_val, 2);
        chk("R2 p step 2", p_addr, 32'h1002);
        chk("R2 m step 4", m_addr, 32'h2004);
        chk("R3 no done mid", xfer_done, 0);
        beat(0);
        beat(0);
        chk("R3 done pulse", xfer_done, 1);
        chk("R3 active clear", active, 0);
        chk("R3 count zero", cnt_val, 0);
        chk("R2 p final", p_addr, 32'h1006);
        chk("R2 m final", m_addr, 32'h200C);
        @(negedge clk);
        chk("R3 done one cycle", xfer_done, 0);
    endtask

    task automatic t_hold;
        set_cfg(2'd1, 0, 2'd2, 1, 2'd0, 0, 0, 0, 0);
        load(3, 2);
        enable(1);
        beat(0);
        chk("R2 p held", p_addr, 32'h1000);
        chk("R2 m step 1", m_addr, 32'h2001);
        chk("R9 p2m src", src_addr, 32'h1000);
        beat(0);
    endtask

    task automatic t_circ;
        set_cfg(2'd0, 1, 2'd2, 1, 2'd2, 1, 0, 0, 0);
        load(3, 2);
        enable(1);
        beat(0);
        beat(0);
        chk("R4 wrap done", xfer_done, 1);
        chk("R4 still active", active, 1);
        chk("R4 count reload", cnt_val, 2);
        chk("R4 p back", p_addr, 32'h1000);
        chk("R4 m back", m_addr, 32'h2000);
        @(negedge clk);
        chk("R4 done one cycle", xfer_done, 0);
        beat(0);
        chk("R4 count after wrap", cnt_val, 1);
        enable(0);
    endtask

    task automatic t_dbuf;
        set_cfg(2'd1, 0, 2'd0, 1, 2'd2, 0, 1, 0, 0);
        load(1, 32'h2000); load(2, 32'h3000); load(3, 2);
        enable(1);
        chk("R5 start ptr0", cur_mem, 0);
        chk("R5 start m", m_addr, 32'h2000);
        beat(0);
        beat(0);
        chk("R5 wrap done", xfer_done, 1);
        chk("R5 toggle", cur_mem, 1);
        chk("R5 m to ptr1", m_addr, 32'h3000);
        chk("R5 active", active, 1);
        load(1, 32'h4000);
        chk("R5 idle rewrite no effect", m_addr, 32'h3000);
        beat(0);
        beat(0);
        chk("R5 toggle back", cur_mem, 0);
        chk("R5 new ptr0", m_addr, 32'h4000);
        enable(0);
    endtask

    task automatic t_pflow;
        set_cfg(2'd1, 1, 2'd0, 1, 2'd0, 0, 0, 1, 0);
        load(3, 2);
        enable(1);
        chk("R6 count all ones", cnt_val, 16'hFFFF);
        beat(0); beat(0); beat(0);
        chk("R6 not ended by count", active, 1);
        chk("R6 count still ones", cnt_val, 16'hFFFF);
        chk("R6 no done", xfer_done, 0);
        beat(1);
        chk("R6 last ends", active, 0);
        chk("R6 done", xfer_done, 1);
    endtask

    task automatic t_illegal;
        load(3, 4);
        set_cfg(2'd2, 1, 2'd0, 1, 2'd0, 1, 0, 0, 0);
        enable(1);
        chk("R7 m2m+circ not started", active, 0);
        chk("R7 m2m+circ err", cfg_err, 1);
        chk("R7 no done", xfer_done, 0);
        set_cfg(2'd0, 1, 2'd0, 1, 2'd1, 0, 0, 0, 1);
        enable(1);
        chk("R7 direct widths", active, 0);
        chk("R7 direct err", cfg_err, 1);
        set_cfg(2'd2, 1, 2'd0, 1, 2'd0, 0, 0, 1, 0);
        enable(1);
        chk("R7 flow+m2m", active, 0);
        set_cfg(2'd2, 1, 2'd0, 1, 2'd0, 0, 0, 0, 0);
        enable(1);
        chk("R7 legal clears err", cfg_err, 0);
        chk("R7 legal starts", active, 1);
        chk("R9 m2m src", src_addr, p_addr);
        enable(0);
    endtask

    task automatic t_zero;
        set_cfg(2'd0, 1, 2'd0, 1, 2'd0, 0, 0, 0, 0);
        load(3, 0);
        enable(1);
        chk("R8 done", xfer_done, 1);
        chk("R8 not active", active, 0);
        @(negedge clk);
        chk("R8 done one cycle", xfer_done, 0);
    endtask

    task automatic t_abort;
        set_cfg(2'd0, 1, 2'd0, 1, 2'd0, 0, 0, 0, 0);
        load(3, 5);
        enable(1);
        beat(0);
        enable(0);
        chk("R10 stopped", active, 0);
        chk("R10 no done", xfer_done, 0);
        chk("R10 count held", cnt_val, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_hold();
        t_circ();
        t_dbuf();
        t_pflow();
        t_illegal();
        t_zero();
        t_abort();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule